// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a 16-bit datapath that performs one register-transfer microoperation on every rising clock edge. A single packed 16-bit control word chooses two source registers, the source of the second operand, the function to apply, where the write-back value comes from, the destination register and whether that write happens at all. An external sequencer or control unit supplies a new control word each cycle. External memory hangs off the address and data outputs and returns data through the data input.

Inside the block are an eight-entry, 16-bit register file with two combinational read ports and one write port, a multiplexer that picks Bus B, a function unit and a write-back multiplexer. The function unit holds an adder with a selectable second operand, a logic unit and a one-position shifter. Bus A leaves the block as the address output and Bus B as the data output. Four status flags (overflow, carry, negative, zero) describe the current function-unit result combinationally.

Top module: `cw_datapath`

## Requirements
- R1: The control word is packed, most significant first, as destination [15:13], A source [12:10], B source [9:7], operand-B select [6], function code [5:2], write-back select [1], write enable [0]. A 3-bit register code 000 to 111 names registers 0 to 7.
- R2: `addr_out` always equals the register named by the A source field, with no clock delay.
- R3: With operand-B select 0, `data_out` is the register named by the B source field. With operand-B select 1, it is `const_in`. The function unit sees the same value as its B operand.
- R4: With write-back select 0, the function result is written. With write-back select 1, `data_in` is written.
- R5: With write enable 1, the write-back value enters the destination register on the rising edge. With write enable 0, no register changes.
- R6: A synchronous active-high reset clears all eight registers to zero.
- R7: When the destination is also a source, the old value is read for the whole cycle, and the new value is seen after the edge.
- R8: Function codes 0000 to 0111 give F = A + Y + cin, where cin is code bit 0. Y is chosen by code bits [2:1]: 00 gives zero, 01 gives B, 10 gives the inverse of B, 11 gives all ones. C is the carry out of bit 15, and V is two's-complement overflow of that sum.
- R9: Codes 1000, 1001, 1010 and 1011 give A AND B, A OR B, A XOR B and NOT A. For these codes V and C are 0.
- R10: Codes 1100 and 1111 pass B. Code 1101 shifts B right by one and code 1110 shifts B left by one; both fill the vacated bit with 0. For these codes V and C are 0.
- R11: N is bit 15 of F and Z is 1 exactly when F is zero, both combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the register file |
| ctrl_word | input | 16 | Packed microoperation control word |
| const_in | input | 16 | External constant that can drive Bus B |
| data_in | input | 16 | External write-back data |
| addr_out | output | 16 | Copy of Bus A |
| data_out | output | 16 | Copy of Bus B |
| flag_v | output | 1 | Signed overflow of the arithmetic result |
| flag_c | output | 1 | Carry out of the arithmetic result |
| flag_n | output | 1 | Result bit 15 |
| flag_z | output | 1 | Result is zero |

## Verification
All sixteen function codes are swept over several operand pairs. Small positive values check the plain sums. The pair 7FFF/0001 tells signed overflow apart from carry. FFFF/0001 raises carry and zero together. 8000/8000 overflows in the negative direction. A one-hot pattern and an alternating pattern separate the logic codes and show the zero fill of the shifts. The write-back source is told apart by keeping `data_in` different from every function result. Write suppression is checked by reading all registers after cycles with writes disabled. The same-register case and the constant operand each get their own sequence.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;
  localparam int REG_AW = 3;
  localparam int FS_W   = 4;
  localparam int CW_W   = 3 * REG_AW + FS_W + 3;

  typedef enum logic [FS_W-1:0] {
    FS_PASS_A  = 4'h0, FS_INC    = 4'h1, FS_ADD    = 4'h2, FS_ADD_C  = 4'h3,
    FS_ADD_NB  = 4'h4, FS_SUB    = 4'h5, FS_DEC    = 4'h6, FS_PASS_AC = 4'h7,
    FS_AND     = 4'h8, FS_OR     = 4'h9, FS_XOR    = 4'hA, FS_NOT    = 4'hB,
    FS_PASS_B  = 4'hC, FS_SHR    = 4'hD, FS_SHL    = 4'hE, FS_PASS_B2 = 4'hF
  } fsel_e;

  typedef struct packed {
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] srca;
    logic [REG_AW-1:0] srcb;
    logic              const_sel;
    fsel_e             fsel;
    logic              din_sel;
    logic              wr_en;
  } ctrl_t;
endpackage

// File: rtl/cwdp_regfile.sv
module cwdp_regfile #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic [AW-1:0]    ra_a,
  input  logic [AW-1:0]    ra_b,
  output logic [WIDTH-1:0] rd_a,
  output logic [WIDTH-1:0] rd_b
);
  logic [WIDTH-1:0] regs [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[gi] <= '0;
      else if (we && (wa == AW'(gi)))
        regs[gi] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];

  // Read port A reads zero in the first cycle after reset.
  assert_rst_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rd_a == '0);

  // A written value is visible on the next cycle.
  assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we) && ra_a == $past(wa)) |-> rd_a == $past(wd));

  // A register keeps its value when no write happens.
  assert_hold_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(we) && ra_a == $past(ra_a)) |-> rd_a == $past(rd_a));
endmodule

// File: rtl/cwdp_arith.sv
module cwdp_arith #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       ysel,
  input  logic             cin,
  output logic [WIDTH-1:0] f,
  output logic             c,
  output logic             v
);
  logic [WIDTH-1:0] y;
  logic [WIDTH:0]   sum;

  always_comb begin
    unique case (ysel)
      2'b00:   y = '0;
      2'b01:   y = b;
      2'b10:   y = ~b;
      default: y = '1;
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  assign f   = sum[WIDTH-1:0];
  assign c   = sum[WIDTH];
  assign v   = (a[WIDTH-1] == y[WIDTH-1]) && (f[WIDTH-1] != a[WIDTH-1]);

  // Incrementing all ones wraps to zero with a carry (R8).
  always_comb begin
    if (ysel == 2'b00 && cin && a == '1)
      assert_inc_wrap_R8: assert (c && f == '0);
  end
endmodule

// File: rtl/cwdp_logic.sv
module cwdp_logic #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             shift_grp,
  input  logic [1:0]       op,
  output logic [WIDTH-1:0] f
);
  logic [WIDTH-1:0] lg, sh;

  always_comb begin
    unique case (op)
      2'b00:   lg = a & b;
      2'b01:   lg = a | b;
      2'b10:   lg = a ^ b;
      default: lg = ~a;
    endcase
  end

  always_comb begin
    unique case (op)
      2'b01:   sh = {1'b0, b[WIDTH-1:1]};
      2'b10:   sh = {b[WIDTH-2:0], 1'b0};
      default: sh = b;
    endcase
  end

  assign f = shift_grp ? sh : lg;
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
  import cwdp_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int NREGS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW_W-1:0]  ctrl_word,
  input  logic [WIDTH-1:0] const_in,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] addr_out,
  output logic [WIDTH-1:0] data_out,
  output logic             flag_v,
  output logic             flag_c,
  output logic             flag_n,
  output logic             flag_z
);
  ctrl_t            cw;
  logic [WIDTH-1:0] bus_a, rd_b, bus_b, bus_d;
  logic [WIDTH-1:0] ar_f, lg_f, fu_f;
  logic             ar_c, ar_v;

  assign cw = ctrl_t'(ctrl_word);

  cwdp_regfile #(.WIDTH(WIDTH), .DEPTH(NREGS)) u_rf (
    .clk(clk), .rst(rst), .we(cw.wr_en), .wa(cw.dst), .wd(bus_d),
    .ra_a(cw.srca), .ra_b(cw.srcb), .rd_a(bus_a), .rd_b(rd_b)
  );

  assign bus_b = cw.const_sel ? const_in : rd_b;

  cwdp_arith #(.WIDTH(WIDTH)) u_arith (
    .a(bus_a), .b(bus_b), .ysel(cw.fsel[2:1]), .cin(cw.fsel[0]),
    .f(ar_f), .c(ar_c), .v(ar_v)
  );

  cwdp_logic #(.WIDTH(WIDTH)) u_logic (
    .a(bus_a), .b(bus_b), .shift_grp(cw.fsel[2]), .op(cw.fsel[1:0]), .f(lg_f)
  );

  assign fu_f  = cw.fsel[3] ? lg_f : ar_f;
  assign bus_d = cw.din_sel ? data_in : fu_f;

  assign addr_out = bus_a;
  assign data_out = bus_b;
  assign flag_v   = !cw.fsel[3] && ar_v;
  assign flag_c   = !cw.fsel[3] && ar_c;
  assign flag_n   = fu_f[WIDTH-1];
  assign flag_z   = (fu_f == '0);

  // External data written back appears on Bus A next cycle.
  assert_din_writeback_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cw.wr_en) && $past(cw.din_sel) && cw.srca == $past(cw.dst))
      |-> addr_out == $past(data_in));

  // Negative and zero never hold together.
  assert_nz_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    flag_n |-> !flag_z);
endmodule

// File: tb/tb_cw_datapath.sv
module tb_cw_datapath;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] ctrl_word, const_in, data_in;
  logic [15:0] addr_out, data_out;
  logic        flag_v, flag_c, flag_n, flag_z;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  logic [15:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cw_datapath dut (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .const_in(const_in),
    .data_in(data_in), .addr_out(addr_out), .data_out(data_out),
    .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
  );

  function automatic logic [15:0] mk(input logic [2:0] da, input logic [2:0] aa,
                                     input logic [2:0] ba, input logic mb,
                                     input logic [3:0] fs, input logic md, input logic rw);
    return {da, aa, ba, mb, fs, md, rw};
  endfunction

  // Returns {v, c, n, z, f} built from the function table of R8 to R11.
  function automatic logic [19:0] ref_fu(input logic [15:0] a, input logic [15:0] b,
                                         input logic [3:0] fs);
    logic [15:0] f;
    logic v, c;
    int   s;
    logic [16:0] u;
    logic [15:0] y;
    v = 1'b0; c = 1'b0;
    if (!fs[3]) begin
      case (fs[2:1])
        2'b00:   y = 16'h0000;
        2'b01:   y = b;
        2'b10:   y = ~b;
        default: y = 16'hFFFF;
      endcase
      u = 17'(a) + 17'(y) + 17'(fs[0]);
      f = u[15:0];
      c = u[16];
      s = int'($signed(a)) + int'($signed(y)) + int'(fs[0]);
      v = (s > 32767) || (s < -32768);
    end else begin
      case (fs[2:0])
        3'b000:  f = a & b;
        3'b001:  f = a | b;
        3'b010:  f = a ^ b;
        3'b011:  f = ~a;
        3'b101:  f = b >> 1;
        3'b110:  f = b << 1;
        default: f = b;
      endcase
    end
    return {v, c, f[15], (f == 16'h0000), f};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [15:0] cw);
    ctrl_word = cw;
    #1;
  endtask

  task automatic write_reg(input logic [2:0] r, input logic [15:0] val);
    data_in = val;
    drive(mk(r, 3'd0, 3'd0, 1'b0, 4'h0, 1'b1, 1'b1));
    tick;
    model[r] = val;
  endtask

  task automatic read_check(input logic [2:0] r, input string req);
    drive(mk(3'd0, r, 3'd0, 1'b0, 4'h0, 1'b0, 1'b0));
    check(req, $sformatf("read R%0d", r), addr_out, model[r]);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    drive(16'h0000);
    tick; tick;
    rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 16'h0000;
    for (int i = 0; i < 8; i++) read_check(3'(i), "R6");
  endtask

  task automatic t_load;
    for (int i = 0; i < 8; i++) write_reg(3'(i), 16'h1100 + 16'(i * 16'h0111));
    for (int i = 0; i < 8; i++) read_check(3'(i), "R4 R1 R2");
  endtask

  task automatic t_bus_b;
    const_in = 16'h1357;
    drive(mk(3'd0, 3'd2, 3'd4, 1'b1, 4'h0, 1'b0, 1'b0));
    check("R3", "constant on Bus B", data_out, 16'h1357);
    check("R2", "Bus A copy", addr_out, model[2]);
    drive(mk(3'd0, 3'd2, 3'd4, 1'b0, 4'h0, 1'b0, 1'b0));
    check("R3", "register on Bus B", data_out, model[4]);
    // R5 <- R2 + constant goes through the function unit.
    drive(mk(3'd5, 3'd2, 3'd4, 1'b1, 4'h2, 1'b0, 1'b1));
    tick;
    model[5] = model[2] + 16'h1357;
    read_check(3'd5, "R3");
  endtask

  task automatic t_function(input logic [15:0] a, input logic [15:0] b);
    logic [19:0] r;
    string req;
    write_reg(3'd1, a);
    write_reg(3'd2, b);
    data_in = 16'hBEEF;
    for (int fs = 0; fs < 16; fs++) begin
      r = ref_fu(a, b, 4'(fs));
      req = (fs < 8) ? "R8" : (fs < 12) ? "R9" : "R10";
      drive(mk(3'd3, 3'd1, 3'd2, 1'b0, 4'(fs), 1'b0, 1'b1));
      check({req, " R11"}, $sformatf("flags fs=%0d a=%h b=%h", fs, a, b),
            {12'h0, flag_v, flag_c, flag_n, flag_z}, {12'h0, r[19:16]});
      tick;
      model[3] = r[15:0];
      read_check(3'd3, req);
    end
  endtask

  task automatic t_no_write;
    data_in = 16'hDEAD;
    for (int i = 0; i < 8; i++) begin
      drive(mk(3'(i), 3'(i), 3'd0, 1'b0, 4'h1, 1'b1, 1'b0));
      tick;
    end
    for (int i = 0; i < 8; i++) read_check(3'(i), "R5");
  endtask

  task automatic t_same_reg;
    logic [15:0] old;
    write_reg(3'd6, 16'h00FF);
    old = model[6];
    drive(mk(3'd6, 3'd6, 3'd6, 1'b0, 4'h2, 1'b0, 1'b1));
    check("R7", "old value during cycle", addr_out, old);
    tick;
    drive(mk(3'd0, 3'd6, 3'd0, 1'b0, 4'h0, 1'b0, 1'b0));
    check("R7", "new value after edge", addr_out, 16'h01FE);
    model[6] = 16'h01FE;
  endtask

  initial begin
    rst = 1'b1;
    ctrl_word = '0;
    const_in  = '0;
    data_in   = '0;
    @(negedge clk);
    t_reset;
    t_load;
    t_bus_b;
    t_function(16'h1234, 16'h0042);
    t_function(16'h7FFF, 16'h0001);
    t_function(16'hFFFF, 16'h0001);
    t_function(16'h8000, 16'h8000);
    t_function(16'h0001, 16'h5555);
    t_no_write;
    t_same_reg;
    t_reset;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule